// File: doc/BRIEF.md
# Width-Selectable Synchronous FIFO with Occupancy Thresholds

This block is a single-clock queue shared by the transmit and receive sides of a serial controller. It holds 256 bytes. A width code, captured when the queue is flushed, sets the element size. Elements can be 8, 16 or 32 bits, so the queue holds 256, 128 or 64 elements. Wider push data is cut down to the element size, and popped elements come back zero-extended.

The queue is driven by a small operation strobe with two bits. The flush bit empties the queue and leaves it stopped. The run bit allows pushes and pops. Writing the operation with both bits clear stops the queue. A 10-bit status word reports the fill level together with full and empty. The remaining outputs compare the occupancy against programmable levels, and neighbouring logic uses them to pace serial traffic or raise transfer requests. One output compares the element count against an 8-bit threshold. Three more compare the occupancy, counted in 32-bit units, against a low, a middle and a high check level of 6 bits each.

Top module: `threshold_fifo`

## Requirements
- R1: After the asynchronous reset the queue is stopped and empty, the width is 8 bits, status reads 10'h200, and overflow and underflow are low.
- R2: An operation write with bit 0 set empties the queue and stops it, even if bit 1 is also set. It takes priority over a push or pop in the same cycle, and the queue stays stopped until the run bit is written.
- R3: An operation write with bit 1 set and bit 0 clear starts the queue, and a write of 0 stops it. The run state changes at the clock edge that takes the write, so a push or pop in that same cycle follows the state held before the write. While the queue is stopped, pushes and pops are ignored: the level is unchanged, no flag is raised and popData keeps its value.
- R4: widthSel is captured at a flush. Code 0 selects 8-bit elements with a capacity of 256, code 1 selects 16-bit elements with a capacity of 128, and codes 2 and 3 select 32-bit elements with a capacity of 64. Push data is truncated to the element width.
- R5: Accepted elements are popped in push order. The popped element appears on popData, zero-extended, one cycle after the pop.
- R6: In the status word, bits 7:0 give the element count modulo 256, bit 8 is full and bit 9 is empty.
- R7: A push while full is dropped, and overflow is high for the following cycle. A pop in the same cycle still completes.
- R8: A pop while empty gives popData = 0 and underflow high for the following cycle. A push in the same cycle is stored.
- R9: thrReached is high whenever the element count is greater than or equal to thrLevel.
- R10: With word level = (occupied bytes)/4 rounded down: lowHit = word level <= chkLow, midHit = word level >= chkMid, and highHit = word level >= chkHigh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opWr | input | 1 | Operation write strobe |
| opVal | input | 2 | Operation value: bit 0 flush, bit 1 run |
| widthSel | input | 2 | Element width code, captured at flush |
| thrLevel | input | 8 | Element-count threshold |
| chkLow | input | 6 | Low check level in 32-bit units |
| chkMid | input | 6 | Middle check level in 32-bit units |
| chkHigh | input | 6 | High check level in 32-bit units |
| pushEn | input | 1 | Push request |
| pushData | input | 32 | Push data, low bits used |
| popEn | input | 1 | Pop request |
| popData | output | 32 | Last popped element, zero-extended |
| status | output | 10 | {empty, full, level[7:0]} |
| thrReached | output | 1 | Count at or above thrLevel |
| lowHit | output | 1 | Word level at or below chkLow |
| midHit | output | 1 | Word level at or above chkMid |
| highHit | output | 1 | Word level at or above chkHigh |
| overflow | output | 1 | Dropped push in previous cycle |
| underflow | output | 1 | Pop of empty queue in previous cycle |

## Verification
The assertions check the following on every cycle. A flush leaves the queue empty and stopped, and a stopped queue holds its level. The level never exceeds the capacity of the selected width. Every overflow pulse traces back to a push against a full queue, and every underflow pulse comes with a zero pop value. Some properties only the bench's scenarios can show. These are data ordering and truncation at each width, the wrap of the status level field when the byte-wide queue is full, and the threshold and check-level outputs across random fill and drain patterns. The bench compares these against its reference queue.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  // strobes issued by the control to the storage datapath
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    logic       rdZero;
    logic       flush;
    logic [1:0] widthCode;
  } fifoStrobeT;

  localparam int STATUS_W = 10;
  localparam int THR_W = 8;
  localparam int CHK_W = 6;
endpackage

// File: rtl/tfifo_ctrl.sv
module tfifo_ctrl
  import tfifo_pkg::*;
#(
  parameter int STORE_BYTES = 256,
  localparam int LVL_W = $clog2(STORE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opWr,
  input  logic [1:0]       opVal,
  input  logic [1:0]       widthSel,
  input  logic             pushEn,
  input  logic             popEn,
  output fifoStrobeT       strb,
  output logic [LVL_W-1:0] level,
  output logic             isFull,
  output logic             isEmpty,
  output logic             overflow,
  output logic             underflow
);
  logic             runQ;
  logic [1:0]       widthQ;
  logic [LVL_W-1:0] levelQ;
  logic [LVL_W-1:0] cap;
  logic             ovQ, unQ;
  logic             flush, wrAcc, rdAcc, rdUnder, wrDrop;

  assign cap     = LVL_W'(STORE_BYTES) >> widthQ;
  assign isFull  = (levelQ == cap);
  assign isEmpty = (levelQ == '0);
  assign flush   = opWr && opVal[0];
  assign wrAcc   = runQ && pushEn && !isFull && !flush;
  assign wrDrop  = runQ && pushEn && isFull && !flush;
  assign rdAcc   = runQ && popEn && !isEmpty && !flush;
  assign rdUnder = runQ && popEn && isEmpty && !flush;

  always_comb begin
    strb.wrEn      = wrAcc;
    strb.rdEn      = rdAcc;
    strb.rdZero    = rdUnder;
    strb.flush     = flush;
    strb.widthCode = widthQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      widthQ <= 2'd0;
      levelQ <= '0;
      ovQ    <= 1'b0;
      unQ    <= 1'b0;
    end else begin
      ovQ <= wrDrop;
      unQ <= rdUnder;
      if (flush) begin
        runQ   <= 1'b0;
        levelQ <= '0;
        widthQ <= (widthSel == 2'd3) ? 2'd2 : widthSel;
      end else begin
        if (opWr) runQ <= opVal[1];
        levelQ <= levelQ + LVL_W'(wrAcc) - LVL_W'(rdAcc);
      end
    end
  end

  assign level     = levelQ;
  assign overflow  = ovQ;
  assign underflow = unQ;

  // R2: a flush leaves the queue empty and stopped
  a_r2_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    (opWr && opVal[0]) |=> (levelQ == '0 && !runQ));
  // R3: a stopped queue without an operation write holds its level
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !opWr) |=> $stable(levelQ));
  // R4: occupancy never exceeds the width-dependent capacity
  a_r4_level_within_cap: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= cap);
  // R7: an overflow pulse follows a push against a full queue
  a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    ovQ |-> $past(pushEn && isFull && runQ));
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store
  import tfifo_pkg::*;
#(
  parameter int STORE_BYTES = 256,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(STORE_BYTES),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobeT        strb,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);
  logic [7:0]        mem [STORE_BYTES];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [DATA_W-1:0] headWord;
  logic [ADDR_W-1:0] step;
  int                entryBytes;

  assign entryBytes = 1 << strb.widthCode;
  assign step       = ADDR_W'(entryBytes);

  // byte-lane writes; only lanes inside the element are stored
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < entryBytes) mem[wrPtr + ADDR_W'(k)] <= pushData[8*k +: 8];
      end
    end
  end

  always_comb begin
    headWord = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < entryBytes) headWord[8*k +: 8] = mem[rdPtr + ADDR_W'(k)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      popData <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= wrPtr + step;
      if (strb.rdEn) begin
        rdPtr   <= rdPtr + step;
        popData <= headWord;
      end else if (strb.rdZero) begin
        popData <= '0;
      end
    end
  end

  // R5: read and write strobes never come together with a flush
  a_r5_no_access_on_flush: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |-> !(strb.wrEn || strb.rdEn || strb.rdZero));
endmodule

// File: rtl/tfifo_levels.sv
module tfifo_levels
  import tfifo_pkg::*;
#(
  parameter int LVL_W = 9
) (
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       widthCode,
  input  logic [THR_W-1:0] thrLevel,
  input  logic [CHK_W-1:0] chkLow,
  input  logic [CHK_W-1:0] chkMid,
  input  logic [CHK_W-1:0] chkHigh,
  output logic             thrReached,
  output logic             lowHit,
  output logic             midHit,
  output logic             highHit
);
  localparam int BYTE_W = LVL_W + 2;
  logic [BYTE_W-1:0] bytesOcc;
  logic [LVL_W-1:0]  wordLvl;

  assign bytesOcc   = {2'b00, level} << widthCode;
  assign wordLvl    = bytesOcc[BYTE_W-1:2];
  assign thrReached = level >= LVL_W'(thrLevel);
  assign lowHit     = wordLvl <= LVL_W'(chkLow);
  assign midHit     = wordLvl >= LVL_W'(chkMid);
  assign highHit    = wordLvl >= LVL_W'(chkHigh);
endmodule

// File: rtl/threshold_fifo.sv
module threshold_fifo
  import tfifo_pkg::*;
#(
  parameter int STORE_BYTES = 256,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWr,
  input  logic [1:0]        opVal,
  input  logic [1:0]        widthSel,
  input  logic [7:0]        thrLevel,
  input  logic [5:0]        chkLow,
  input  logic [5:0]        chkMid,
  input  logic [5:0]        chkHigh,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic [9:0]        status,
  output logic              thrReached,
  output logic              lowHit,
  output logic              midHit,
  output logic              highHit,
  output logic              overflow,
  output logic              underflow
);
  localparam int LVL_W = $clog2(STORE_BYTES) + 1;

  fifoStrobeT       strb;
  logic [LVL_W-1:0] level;
  logic             isFull, isEmpty;

  tfifo_ctrl #(.STORE_BYTES(STORE_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .opWr(opWr), .opVal(opVal), .widthSel(widthSel),
    .pushEn(pushEn), .popEn(popEn), .strb(strb), .level(level),
    .isFull(isFull), .isEmpty(isEmpty), .overflow(overflow), .underflow(underflow)
  );

  tfifo_store #(.STORE_BYTES(STORE_BYTES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .pushData(pushData), .popData(popData)
  );

  tfifo_levels #(.LVL_W(LVL_W)) u_levels (
    .level(level), .widthCode(strb.widthCode), .thrLevel(thrLevel),
    .chkLow(chkLow), .chkMid(chkMid), .chkHigh(chkHigh),
    .thrReached(thrReached), .lowHit(lowHit), .midHit(midHit), .highHit(highHit)
  );

  assign status = {isEmpty, isFull, level[7:0]};

  // R8: an underflow pulse always comes with a zero pop value
  a_r8_underflow_zero: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> (popData == '0));
endmodule

// File: tb/threshold_fifo_tb.sv
module threshold_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opWr = 1'b0;
  logic [1:0]  opVal = 2'd0;
  logic [1:0]  widthSel = 2'd0;
  logic [7:0]  thrLevel = 8'd5;
  logic [5:0]  chkLow = 6'd0, chkMid = 6'd16, chkHigh = 6'd60;
  logic        pushEn = 1'b0;
  logic [31:0] pushData = '0;
  logic        popEn = 1'b0;
  logic [31:0] popData;
  logic [9:0]  status;
  logic        thrReached, lowHit, midHit, highHit, overflow, underflow;

  threshold_fifo u_dut (
    .clk(clk), .rstN(rstN), .opWr(opWr), .opVal(opVal), .widthSel(widthSel),
    .thrLevel(thrLevel), .chkLow(chkLow), .chkMid(chkMid), .chkHigh(chkHigh),
    .pushEn(pushEn), .pushData(pushData), .popEn(popEn), .popData(popData),
    .status(status), .thrReached(thrReached), .lowHit(lowHit), .midHit(midHit),
    .highHit(highHit), .overflow(overflow), .underflow(underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model
  logic [31:0] mq[$];
  bit          mRun = 0;
  int          mW = 0;
  bit          mOv = 0, mUn = 0;
  logic [31:0] mPop = '0;

  function automatic int capOf(int w);
    return 256 >> w;
  endfunction
  function automatic logic [31:0] maskOf(int w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string ctx);
    int n = mq.size();
    int wl = (n << mW) >> 2;
    logic [9:0] st;
    st = {n == 0, n == capOf(mW), 8'(n)};
    chk({"R6 status ", ctx}, 32'(status), 32'(st));
    chk({"R7 overflow ", ctx}, 32'(overflow), 32'(mOv));
    chk({"R8 underflow ", ctx}, 32'(underflow), 32'(mUn));
    chk({"R5 popData ", ctx}, popData, mPop);
    chk({"R9 thrReached ", ctx}, 32'(thrReached), 32'(n >= int'(thrLevel)));
    chk({"R10 levels ", ctx}, {29'd0, lowHit, midHit, highHit},
        {29'd0, wl <= int'(chkLow), wl >= int'(chkMid), wl >= int'(chkHigh)});
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit ow, logic [1:0] ov, bit pu, logic [31:0] pd, bit po, string ctx);
    bit oldRun;
    bit wasFull, wasEmpty;
    opWr = ow; opVal = ov; pushEn = pu; pushData = pd; popEn = po;
    @(posedge clk);
    oldRun = mRun;
    mOv = 0; mUn = 0;
    if (ow && ov[0]) begin
      mq.delete();
      mRun = 0;
      mW = (widthSel == 2'd3) ? 2 : int'(widthSel);
    end else begin
      wasFull = (mq.size() == capOf(mW));
      wasEmpty = (mq.size() == 0);
      if (oldRun && po) begin
        if (wasEmpty) begin mPop = '0; mUn = 1; end
        else mPop = mq.pop_front();
      end
      if (oldRun && pu) begin
        if (wasFull) mOv = 1;
        else mq.push_back(pd & maskOf(mW));
      end
      if (ow) mRun = ov[1];
    end
    @(negedge clk);
    opWr = 0; pushEn = 0; popEn = 0;
    checkAll(ctx);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset status", 32'(status), 32'h200);
    chk("R1 reset flags", {30'd0, overflow, underflow}, 32'd0);
    checkAll("R1");
    // R3: stopped after reset, push and pop ignored
    step(0, 2'd0, 1, 32'h11, 1, "R3 stopped ignore");
    // R2: flush with run bit and push together stays stopped and empty
    widthSel = 2'd1;
    step(1, 2'd3, 1, 32'h22, 0, "R2 flush priority");
    step(0, 2'd0, 1, 32'h33, 0, "R2 still stopped");
    // R3: start then push
    step(1, 2'd2, 0, 0, 0, "R3 start");
    // R4 16-bit truncation
    step(0, 2'd0, 1, 32'hABCD_1234, 0, "R4 push16");
    step(0, 2'd0, 0, 0, 1, "R4 pop16");
    chk("R4 truncated", popData, 32'h0000_1234);
    // R8 underflow with simultaneous push
    step(0, 2'd0, 1, 32'h5A5A, 1, "R8 under+push");
    chk("R8 underflow pulse", 32'(underflow), 32'd1);
    // R3 stop: write zero, then pop ignored
    step(1, 2'd0, 0, 0, 0, "R3 stop");
    step(0, 2'd0, 0, 0, 1, "R3 pop while stopped");
    // R4 byte mode fill to 256, status wraps
    widthSel = 2'd0;
    step(1, 2'd1, 0, 0, 0, "R4 flush byte");
    step(1, 2'd2, 0, 0, 0, "R4 start byte");
    for (int i = 0; i < 256; i++) step(0, 2'd0, 1, 32'(i * 7 + 3), 0, "R4 fill byte");
    chk("R6 full wrap", 32'(status), 32'h100);
    // R7 overflow with simultaneous pop
    step(0, 2'd0, 1, 32'hEE, 1, "R7 over+pop");
    chk("R7 overflow pulse", 32'(overflow), 32'd1);
    for (int i = 0; i < 256; i++) step(0, 2'd0, 0, 0, 1, "R5 drain byte");
    // R4 code 3 behaves as 32-bit, capacity 64
    widthSel = 2'd3;
    step(1, 2'd1, 0, 0, 0, "R4 flush w3");
    step(1, 2'd2, 0, 0, 0, "R4 start w3");
    for (int i = 0; i < 65; i++) step(0, 2'd0, 1, 32'hC000_0000 + 32'(i), 0, "R4 fill w3");
    chk("R4 cap64 full", 32'(status), 32'h140);

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      widthSel = 2'(ph % 4);
      thrLevel = 8'($urandom_range(0, 255));
      chkLow = 6'($urandom_range(0, 63));
      chkMid = 6'($urandom_range(0, 63));
      chkHigh = 6'($urandom_range(0, 63));
      step(1, 2'd1, 0, 0, 0, "R2 rand flush");
      step(1, 2'd2, 0, 0, 0, "R3 rand start");
      for (int i = 0; i < 600; i++) begin
        int pPush = (i < 350) ? 80 : 25;
        bit pu = ($urandom_range(0, 99) < pPush);
        bit po = ($urandom_range(0, 99) < (100 - pPush));
        bit ow = ($urandom_range(0, 99) < 2);
        logic [1:0] ov = ow ? 2'($urandom_range(0, 2) * 2 == 4 ? 0 : 2) : 2'd0;
        step(ow, ov, pu, $urandom, po, "R5 random");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule